// File: doc/BRIEF.md
# Dual Event Counter with Cascade Mode

This block counts rising edges on two external event pins. The pins are not tied to the system clock. Each pin passes through its own synchronizer and edge detector. A mode bit selects how the two 8-bit halves are used. In split mode each half counts its own pin. In cascade mode the halves form one 16-bit counter. That counter is driven by the low pin, and a low-half carry advances the high half.

Each half has three controls of its own: a run enable, a release control that holds the half at zero while it is 0, and a sticky overflow flag. Every overflow also sets a shared interrupt flag. The interrupt output is asserted only while the interrupt enable is set.

Software uses a small register port with four byte registers: control, status and two count registers. Reads are registered. The count registers are read-only.

Top module: `evt_pair_counter`

## Requirements
- R1: With control bit 0 (split) = 1, the low count (address 2) advances once per rising edge of `evt_lo_i`. The high count (address 3) advances once per rising edge of `evt_hi_i`. The two halves are independent.
- R2: A half at 0xFF that receives one more counted event wraps to 0x00 and then keeps counting up.
- R3: With split = 0, the two counts form one 16-bit value. Only `evt_lo_i` advances it, a low-half carry increments the high half, and `evt_hi_i` has no effect.
- R4: In cascade mode, a wrap from 0xFFFF to 0x0000 sets status bit 1 (high overflow) and leaves status bit 0 (low overflow) at 0. In split mode, a low wrap sets bit 0 and a high wrap sets bit 1.
- R5: A pin held high for many cycles counts exactly once.
- R6: Events on a pin are ignored while its run bit is 0. The run bits are control bit 1 (low) and control bit 2 (high).
- R7: While a release bit is 0, its half reads 0x00 and ignores events. The release bits are control bit 3 (low) and control bit 4 (high). Counting resumes from zero when the bit is set to 1.
- R8: Any overflow sets status bit 2 (interrupt flag). `irq_o` is 1 only while both the interrupt flag and control bit 5 (interrupt enable) are 1.
- R9: Status flags stay set until software writes 0 to the bit. Writing 1 to a status bit has no effect.
- R10: If a write that clears a flag and a new overflow that sets it fall in the same cycle, the flag ends up set.
- R11: After reset, every register reads 0 and `irq_o` is 0. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_lo_i | input | 1 | Asynchronous event pin, low half |
| evt_hi_i | input | 1 | Asynchronous event pin, high half |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 low count, 3 high count |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Registered, gated interrupt request |

## Verification
Two functions can fall in the same cycle: a software write of 0 that clears an overflow flag, and a new overflow that sets the same flag. The bench brings the low half to 0xFF and raises its pin. It then places the status write on exactly the clock edge where the synchronized edge increments the counter, which is the third edge after the pin rises. A status read afterwards must show both the low overflow flag and the interrupt flag still set.

// File: rtl/evt_pair_pkg.sv
package evt_pair_pkg;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = 8;
  localparam int REG_CTRL = 0;
  localparam int REG_STAT = 1;
  localparam int REG_CNLO = 2;
  localparam int REG_CNHI = 3;
  localparam int CTRL_W   = 6;

  // Packed so that split is bit 0 and irq_en is bit 5 of the control byte.
  typedef struct packed {
    logic irq_en;
    logic rel_hi;
    logic rel_lo;
    logic run_hi;
    logic run_lo;
    logic split;
  } ctrl_t;

  localparam int STAT_OVF_LO = 0;
  localparam int STAT_OVF_HI = 1;
  localparam int STAT_IRQF   = 2;
endpackage

// File: rtl/evt_pair_sync.sv
module evt_pair_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;

  // R5: one edge of the pin yields a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/evt_pair_half.sv
module evt_pair_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rel,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || !rel) count <= '0;
    else if (inc)    count <= count + 1'b1;
  end

  assign wrap = rel & inc & (count == TOP);

  // R7: a held half reads zero
  a_r7_held_zero: assert property (@(posedge clk) disable iff (rst)
    !rel |=> count == '0);
  // R2: a wrap returns the half to zero
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |=> count == '0);
  // R6: without an increment the count holds
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (rel && !inc) |=> $stable(count));
endmodule

// File: rtl/evt_pair_regs.sv
module evt_pair_regs
  import evt_pair_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              set_lo,
  input  logic              set_hi,
  input  logic [CNT_W-1:0]  cnt_lo,
  input  logic [CNT_W-1:0]  cnt_hi,
  output ctrl_t             ctrl,
  output logic              irq_o
);
  logic ovf_lo, ovf_hi, irqf;
  logic wr_ctrl, wr_stat, rd_en;
  logic clr_lo, clr_hi, clr_irq;

  assign wr_ctrl = bus_sel & bus_wr & (bus_addr == ADDR_W'(REG_CTRL));
  assign wr_stat = bus_sel & bus_wr & (bus_addr == ADDR_W'(REG_STAT));
  assign rd_en   = bus_sel & ~bus_wr;
  assign clr_lo  = wr_stat & ~bus_wdata[STAT_OVF_LO];
  assign clr_hi  = wr_stat & ~bus_wdata[STAT_OVF_HI];
  assign clr_irq = wr_stat & ~bus_wdata[STAT_IRQF];

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (wr_ctrl) ctrl <= bus_wdata[CTRL_W-1:0];
  end

  // A new overflow takes priority over a clearing write.
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_lo <= 1'b0;
      ovf_hi <= 1'b0;
      irqf   <= 1'b0;
    end else begin
      ovf_lo <= set_lo | (ovf_lo & ~clr_lo);
      ovf_hi <= set_hi | (ovf_hi & ~clr_hi);
      irqf   <= set_lo | set_hi | (irqf & ~clr_irq);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= irqf & ctrl.irq_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      case (bus_addr)
        ADDR_W'(REG_CTRL): bus_rdata <= DATA_W'(ctrl);
        ADDR_W'(REG_STAT): bus_rdata <= DATA_W'({irqf, ovf_hi, ovf_lo});
        ADDR_W'(REG_CNLO): bus_rdata <= DATA_W'(cnt_lo);
        default:           bus_rdata <= DATA_W'(cnt_hi);
      endcase
    end
  end

  // R10: an overflow sets its flag even against a clearing write
  a_r10_set_wins_lo: assert property (@(posedge clk) disable iff (rst)
    set_lo |=> (ovf_lo && irqf));
  a_r10_set_wins_hi: assert property (@(posedge clk) disable iff (rst)
    set_hi |=> (ovf_hi && irqf));
  // R9: a flag stays until a zero is written to it
  a_r9_sticky_lo: assert property (@(posedge clk) disable iff (rst)
    (ovf_lo && !clr_lo) |=> ovf_lo);
  a_r9_sticky_hi: assert property (@(posedge clk) disable iff (rst)
    (ovf_hi && !clr_hi) |=> ovf_hi);
  // R8: no request without a pending flag
  a_r8_no_irq_without_flag: assert property (@(posedge clk) disable iff (rst)
    !irqf |=> !irq_o);
endmodule

// File: rtl/evt_pair_counter.sv
module evt_pair_counter
  import evt_pair_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_lo_i,
  input  logic              evt_hi_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int NCH = 2;

  ctrl_t            ctrl;
  logic [NCH-1:0]   pins, rise;
  logic             inc_lo, inc_hi, wrap_lo, wrap_hi, set_lo, set_hi;
  logic [CNT_W-1:0] cnt_lo, cnt_hi;

  assign pins = {evt_hi_i, evt_lo_i};

  for (genvar g = 0; g < NCH; g++) begin : g_sync
    evt_pair_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .pin (pins[g]),
      .rise(rise[g])
    );
  end

  // Split mode: each half follows its own pin. Cascade: the low carry drives the high half.
  assign inc_lo = rise[0] & ctrl.run_lo;
  assign inc_hi = ctrl.split ? (rise[1] & ctrl.run_hi) : (wrap_lo & ctrl.run_hi);

  evt_pair_half #(.W(CNT_W)) u_lo (
    .clk(clk), .rst(rst), .rel(ctrl.rel_lo), .inc(inc_lo), .count(cnt_lo), .wrap(wrap_lo)
  );
  evt_pair_half #(.W(CNT_W)) u_hi (
    .clk(clk), .rst(rst), .rel(ctrl.rel_hi), .inc(inc_hi), .count(cnt_hi), .wrap(wrap_hi)
  );

  assign set_lo = wrap_lo & ctrl.split;
  assign set_hi = wrap_hi;

  evt_pair_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .set_lo   (set_lo),
    .set_hi   (set_hi),
    .cnt_lo   (cnt_lo),
    .cnt_hi   (cnt_hi),
    .ctrl     (ctrl),
    .irq_o    (irq_o)
  );

  // R3: in cascade mode the high pin does not move the high half
  a_r3_hi_pin_ignored: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.split && ctrl.rel_hi && !wrap_lo) |=> $stable(cnt_hi));
  // R4: in cascade mode a low wrap never sets the low flag
  a_r4_cascade_no_lo_set: assert property (@(posedge clk) disable iff (rst)
    !ctrl.split |-> !set_lo);
  // R1: in split mode a high-half step needs a high-pin edge
  a_r1_split_hi_source: assert property (@(posedge clk) disable iff (rst)
    (ctrl.split && inc_hi) |-> rise[1]);
endmodule

// File: tb/evt_pair_counter_bench.sv
module evt_pair_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evt_lo_i = 1'b0, evt_hi_i = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  evt_pair_counter u_evt_pair_counter (
    .clk(clk), .rst(rst), .evt_lo_i(evt_lo_i), .evt_hi_i(evt_hi_i),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  localparam logic [7:0] C_SPLIT = 8'h01, C_RUNLO = 8'h02, C_RUNHI = 8'h04,
                         C_RELLO = 8'h08, C_RELHI = 8'h10, C_IEN = 8'h20;

  function automatic logic [7:0] stat_exp(input logic lo, input logic hi, input logic f);
    return {5'b0, f, hi, lo};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string req);
    logic [7:0] got;
    rd(a, got);
    check(got === e, req, got, e);
  endtask

  // Pins high for 'hold' cycles, then low for 'hold' cycles.
  task automatic ev(input logic lo, input logic hi, input int hold);
    @(negedge clk);
    evt_lo_i = lo; evt_hi_i = hi;
    repeat (hold) @(negedge clk);
    evt_lo_i = 1'b0; evt_hi_i = 1'b0;
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic burst(input logic lo, input logic hi, input int n);
    for (int i = 0; i < n; i++) ev(lo, hi, 1);
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 195000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<195000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : main
    int elo, ehi;
    logic olo, ohi, oirq;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    expect_reg(2'd0, 8'h00, "R11 ctrl");
    expect_reg(2'd1, 8'h00, "R11 stat");
    expect_reg(2'd2, 8'h00, "R11 cnt_lo");
    expect_reg(2'd3, 8'h00, "R11 cnt_hi");
    check(irq_o === 1'b0, "R11 irq", irq_o, 0);

    // R1 split counting
    wr(2'd0, C_SPLIT | C_RUNLO | C_RUNHI | C_RELLO | C_RELHI);
    for (int i = 0; i < 5; i++) ev(1'b1, i < 3, 3);
    repeat (4) @(negedge clk);
    expect_reg(2'd2, 8'd5, "R1 lo");
    expect_reg(2'd3, 8'd3, "R1 hi");

    // R5 long high level counts once
    ev(1'b1, 1'b0, 20);
    repeat (4) @(negedge clk);
    expect_reg(2'd2, 8'd6, "R5 held");

    // R6 run disabled on low half
    wr(2'd0, C_SPLIT | C_RUNHI | C_RELLO | C_RELHI);
    burst(1'b1, 1'b1, 4);
    expect_reg(2'd2, 8'd6, "R6 lo ignored");
    expect_reg(2'd3, 8'd7, "R6 hi counts");

    // R11 count registers are read-only
    wr(2'd2, 8'hAA);
    wr(2'd3, 8'h55);
    expect_reg(2'd2, 8'd6, "R11 lo write ignored");
    expect_reg(2'd3, 8'd7, "R11 hi write ignored");

    // R7 hold at zero
    wr(2'd0, C_SPLIT | C_RUNLO | C_RUNHI | C_RELHI);
    expect_reg(2'd2, 8'd0, "R7 held zero");
    burst(1'b1, 1'b0, 2);
    expect_reg(2'd2, 8'd0, "R7 events ignored");
    wr(2'd0, C_SPLIT | C_RUNLO | C_RUNHI | C_RELLO | C_RELHI);
    burst(1'b1, 1'b0, 3);
    expect_reg(2'd2, 8'd3, "R7 resumes");

    // R2 / R8 wrap of low half, interrupt gated off
    burst(1'b1, 1'b0, 252);
    expect_reg(2'd2, 8'hFF, "R2 at top");
    expect_reg(2'd1, 8'h00, "R2 no flag yet");
    burst(1'b1, 1'b0, 1);
    expect_reg(2'd2, 8'h00, "R2 wrapped");
    expect_reg(2'd1, stat_exp(1, 0, 1), "R8 flags");
    check(irq_o === 1'b0, "R8 gated off", irq_o, 0);
    burst(1'b1, 1'b0, 2);
    expect_reg(2'd2, 8'd2, "R2 keeps counting");
    wr(2'd0, C_SPLIT | C_RUNLO | C_RUNHI | C_RELLO | C_RELHI | C_IEN);
    repeat (3) @(negedge clk);
    check(irq_o === 1'b1, "R8 enabled", irq_o, 1);

    // R9 writing ones keeps flags, zeros clear them
    wr(2'd1, 8'hFF);
    expect_reg(2'd1, stat_exp(1, 0, 1), "R9 ones no effect");
    wr(2'd1, 8'h00);
    expect_reg(2'd1, 8'h00, "R9 cleared");
    repeat (2) @(negedge clk);
    check(irq_o === 1'b0, "R9 irq drops", irq_o, 0);

    // R10 clear write on the overflow edge
    burst(1'b1, 1'b0, 253);
    expect_reg(2'd2, 8'hFF, "R10 at top");
    @(negedge clk);
    evt_lo_i = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h00;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; evt_lo_i = 1'b0;
    repeat (4) @(negedge clk);
    expect_reg(2'd1, stat_exp(1, 0, 1), "R10 set wins");
    expect_reg(2'd2, 8'h00, "R10 wrapped");

    // Random split-mode traffic against a bench model (R1 R2 R8)
    wr(2'd1, 8'h00);
    elo = 0; ehi = 0;
    rd(2'd3, rv); ehi = rv;
    olo = 0; ohi = 0; oirq = 0;
    for (int r = 0; r < 40; r++) begin
      int n;
      logic ml, mh;
      n  = 1 + ($urandom % 12);
      ml = $urandom % 2;
      mh = $urandom % 2;
      for (int k = 0; k < n; k++) begin
        logic pl, ph;
        pl = ml | (($urandom % 3) == 0);
        ph = mh | (($urandom % 3) == 0);
        ev(pl, ph, 1 + ($urandom % 3));
        if (pl) begin
          if (elo == 255) begin elo = 0; olo = 1; oirq = 1; end else elo++;
        end
        if (ph) begin
          if (ehi == 255) begin ehi = 0; ohi = 1; oirq = 1; end else ehi++;
        end
      end
      repeat (4) @(negedge clk);
      expect_reg(2'd2, 8'(elo), "R1 random lo");
      expect_reg(2'd3, 8'(ehi), "R1 random hi");
      if (r % 10 == 9) expect_reg(2'd1, stat_exp(olo, ohi, oirq), "R2 random flags");
    end

    // R3 / R4 cascade mode
    wr(2'd1, 8'h00);
    wr(2'd0, C_RUNLO | C_RUNHI);
    wr(2'd0, C_RUNLO | C_RUNHI | C_RELLO | C_RELHI | C_IEN);
    burst(1'b1, 1'b0, 300);
    expect_reg(2'd2, 8'd44, "R3 lo part");
    expect_reg(2'd3, 8'd1, "R3 carry");
    expect_reg(2'd1, 8'h00, "R4 low wrap sets nothing");
    burst(1'b0, 1'b1, 3);
    expect_reg(2'd3, 8'd1, "R3 hi pin ignored");
    burst(1'b1, 1'b0, 65535 - 300);
    expect_reg(2'd2, 8'hFF, "R4 lo top");
    expect_reg(2'd3, 8'hFF, "R4 hi top");
    expect_reg(2'd1, 8'h00, "R4 no flag before wrap");
    burst(1'b1, 1'b0, 1);
    expect_reg(2'd2, 8'h00, "R4 lo wrapped");
    expect_reg(2'd3, 8'h00, "R4 hi wrapped");
    expect_reg(2'd1, stat_exp(0, 1, 1), "R4 hi flag only");
    check(irq_o === 1'b1, "R8 cascade irq", irq_o, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule